// File: doc/BRIEF.md
# Transmit Path Local Fault Monitor

This block watches the digital side of a bus transmitter and decides when the transmitter may drive. It has three jobs. It raises a local-failure flag and turns the driver off for faults that would lock the bus. It flags a bus held dominant from outside without touching the driver. It qualifies a shorted bus line over several consecutive transmit cycles before it reports a bus failure. The analog comparators for bus shorts, transmit-to-receive shorts and junction temperature sit outside the block and arrive as plain levels. A shared timebase tick sets the scale of both dwell timeouts.

Each class of fault clears in its own way. Faults that switch the driver off are latched until a release event arrives, and a release only counts once every latched cause has gone. The external-clamp indication follows the bus and is not stored. The bus-failure flag is kept until normal operation is entered again. The controller selects the operating mode, and the mode decides which detectors are armed.

Top module: `txfault_monitor`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `bus_fail` = 0, `local_fail` = 0 and `tx_en` = 1.
- R2: In a monitored mode (`mode` = 2'd1 normal or 2'd2 listen-only), `txd` = 0 (dominant) held for more than `TXD_TO_TICKS` ticks drives `tx_en` to 0 and `local_fail` to 1.
- R3: In a monitored mode, `bus_dom` = 1 held for more than `BUS_TO_TICKS` ticks sets `local_fail` to 1 and leaves `tx_en` unchanged.
- R4: The bus-clamp indication is not stored. One cycle after `bus_dom` returns to 0, `local_fail` is 0 unless a latched fault is present.
- R5: After a latched fault (R2, R7), `tx_en` stays 0 and `local_fail` stays 1 until a release under R6, even after the cause has gone away.
- R6: A latched fault is released on entry into normal mode, or on a cycle with `bus_dom` = 1 and `txd` = 1. In both cases the release happens only if `txd` = 1, `overtemp` = 0 and `txrx_short` = 0 in that cycle.
- R7: In a monitored mode, `overtemp` = 1 or `txrx_short` = 1 drives `tx_en` to 0 and `local_fail` to 1 on the next cycle.
- R8: In standby (2'd0) or sleep (2'd3), no local fault is detected, and `tx_en` and `local_fail` do not change because of `txd`, `bus_dom`, `overtemp` or `txrx_short`.
- R9: In normal mode with `tx_en` = 1, a `txd` rising edge (dominant to recessive) that comes with `bus_short` = 1 is a failing cycle. A rising edge with `bus_short` = 0 resets the run. `bus_fail` rises after `FAIL_CYCLES` failing cycles in a row.
- R10: `bus_fail` stays set while the mode changes among other modes, and it clears on the cycle after normal mode is entered.
- R11: Both dwell timers advance only on cycles with `tick` = 1. Without ticks, no timeout occurs however long the condition holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timebase strobe for the dwell timers |
| txd | input | 1 | Transmit level from the controller, 0 = dominant |
| bus_dom | input | 1 | Digitised bus level, 1 = dominant |
| bus_short | input | 1 | Bus line short comparator result |
| txrx_short | input | 1 | Transmit-to-receive pin short comparator result |
| overtemp | input | 1 | Junction over-temperature indication |
| mode | input | 2 | Operating mode: 0 standby, 1 normal, 2 listen-only, 3 sleep |
| bus_fail | output | 1 | Qualified bus failure flag |
| local_fail | output | 1 | Local failure flag |
| tx_en | output | 1 | Transmitter enable |

## Verification
A dwell counter that is off by one moves the fall of `tx_en`, or the rise of `local_fail`, by one cycle away from the tick that should expire it. The per-clock comparison catches that on the first clock where the two differ. A wrong latch term shows up as `tx_en` coming back too early or staying off after a valid release, and this is visible on the cycle after the release stimulus. A failing-cycle counter that does not restart on a good cycle shows up as a `bus_fail` rise at the fourth failing edge of an interrupted sequence.

// File: rtl/txf_pkg.sv
package txf_pkg;

  typedef enum logic [1:0] {
    OPM_STANDBY = 2'd0,
    OPM_NORMAL  = 2'd1,
    OPM_LISTEN  = 2'd2,
    OPM_SLEEP   = 2'd3
  } opmode_e;

  function automatic logic opm_monitored(opmode_e m);
    return (m == OPM_NORMAL) || (m == OPM_LISTEN);
  endfunction

endpackage

// File: rtl/txf_dwell_timer.sv
module txf_dwell_timer #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic active,
  output logic expired
);
  localparam int TW = $clog2(LIMIT + 1);
  localparam logic [TW-1:0] TOP = TW'(LIMIT);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      cnt_q <= '0;
    end else if (tick && (cnt_q != TOP)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expired = active && (cnt_q == TOP);
endmodule

// File: rtl/txf_cycle_qual.sv
module txf_cycle_qual #(
  parameter int CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic txd,
  input  logic bus_short,
  input  logic armed,
  input  logic restart,
  output logic bus_fail
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic          txd_q;
  logic [CW-1:0] run_q;
  logic          flag_q;
  logic          rise;

  assign rise = !txd_q && txd;

  always_ff @(posedge clk) begin
    if (rst) begin
      txd_q  <= 1'b1;
      run_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      txd_q <= txd;
      if (restart) begin
        run_q  <= '0;
        flag_q <= 1'b0;
      end else if (!armed) begin
        run_q <= '0;
      end else if (rise) begin
        if (!bus_short) begin
          run_q <= '0;
        end else if (run_q == LAST) begin
          flag_q <= 1'b1;
        end else begin
          run_q <= run_q + 1'b1;
        end
      end
    end
  end

  assign bus_fail = flag_q;
endmodule

// File: rtl/txf_fault_latch.sv
module txf_fault_latch (
  input  logic clk,
  input  logic rst,
  input  logic mon,
  input  logic enter_normal,
  input  logic txd,
  input  logic bus_dom,
  input  logic txd_expired,
  input  logic bus_expired,
  input  logic overtemp,
  input  logic txrx_short,
  output logic tx_en,
  output logic local_fail
);
  logic en_q, lf_q;
  logic set_fault, resolved, release_ok, en_nxt;

  assign set_fault  = mon && (txd_expired || overtemp || txrx_short);
  assign resolved   = txd && !overtemp && !txrx_short;
  assign release_ok = resolved && (enter_normal || bus_dom);

  always_comb begin
    en_nxt = en_q;
    if (set_fault)       en_nxt = 1'b0;
    else if (release_ok) en_nxt = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= 1'b1;
      lf_q <= 1'b0;
    end else begin
      en_q <= en_nxt;
      lf_q <= !en_nxt || (mon && bus_expired);
    end
  end

  assign tx_en      = en_q;
  assign local_fail = lf_q;
endmodule

// File: rtl/txfault_monitor.sv
module txfault_monitor #(
  parameter int TXD_TO_TICKS = 8,
  parameter int BUS_TO_TICKS = 12,
  parameter int FAIL_CYCLES  = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       txd,
  input  logic       bus_dom,
  input  logic       bus_short,
  input  logic       txrx_short,
  input  logic       overtemp,
  input  logic [1:0] mode,
  output logic       bus_fail,
  output logic       local_fail,
  output logic       tx_en
);
  import txf_pkg::*;

  opmode_e mode_e, mode_q;
  logic    mon, enter_normal;
  logic    txd_exp, bus_exp;

  assign mode_e       = opmode_e'(mode);
  assign mon          = opm_monitored(mode_e);
  assign enter_normal = (mode_e == OPM_NORMAL) && (mode_q != OPM_NORMAL);

  always_ff @(posedge clk) begin
    if (rst) mode_q <= OPM_STANDBY;
    else     mode_q <= mode_e;
  end

  txf_dwell_timer #(.LIMIT(TXD_TO_TICKS)) u_txd_tmr (
    .clk(clk), .rst(rst), .tick(tick),
    .active(mon && !txd), .expired(txd_exp)
  );

  txf_dwell_timer #(.LIMIT(BUS_TO_TICKS)) u_bus_tmr (
    .clk(clk), .rst(rst), .tick(tick),
    .active(mon && bus_dom), .expired(bus_exp)
  );

  txf_fault_latch u_latch (
    .clk(clk), .rst(rst), .mon(mon), .enter_normal(enter_normal),
    .txd(txd), .bus_dom(bus_dom), .txd_expired(txd_exp),
    .bus_expired(bus_exp), .overtemp(overtemp), .txrx_short(txrx_short),
    .tx_en(tx_en), .local_fail(local_fail)
  );

  txf_cycle_qual #(.CYCLES(FAIL_CYCLES)) u_qual (
    .clk(clk), .rst(rst), .txd(txd), .bus_short(bus_short),
    .armed((mode_e == OPM_NORMAL) && tx_en), .restart(enter_normal),
    .bus_fail(bus_fail)
  );
endmodule

// File: rtl/txfault_monitor_chk.sv
module txfault_monitor_chk (
  input logic       clk,
  input logic       rst,
  input logic       txd,
  input logic       bus_dom,
  input logic       txrx_short,
  input logic       overtemp,
  input logic [1:0] mode,
  input logic       bus_fail,
  input logic       local_fail,
  input logic       tx_en
);
  logic mon;
  assign mon = (mode == 2'd1) || (mode == 2'd2);

  AST_HAZARD_DISABLES: assert property (@(posedge clk) disable iff (rst)
    (mon && (overtemp || txrx_short)) |=> !tx_en); // R7

  AST_DISABLE_HELD: assert property (@(posedge clk) disable iff (rst)
    (!tx_en && !(txd && !overtemp && !txrx_short && (bus_dom || mode == 2'd1)))
    |=> !tx_en); // R5

  AST_CLAMP_SPARES_TX: assert property (@(posedge clk) disable iff (rst)
    (tx_en && txd && !overtemp && !txrx_short) |=> tx_en); // R3

  AST_CLAMP_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (tx_en && txd && !bus_dom && !overtemp && !txrx_short) |=> !local_fail); // R4

  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    $rose(local_fail) |-> $past(mon)); // R8

  AST_BUSFAIL_IN_NORMAL: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_fail) |-> $past(mode == 2'd1)); // R9

  AST_BUSFAIL_CLEARED: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd1 && $past(mode) != 2'd1) |=> !bus_fail); // R10
endmodule

bind txfault_monitor txfault_monitor_chk u_chk (
  .clk(clk), .rst(rst), .txd(txd), .bus_dom(bus_dom),
  .txrx_short(txrx_short), .overtemp(overtemp), .mode(mode),
  .bus_fail(bus_fail), .local_fail(local_fail), .tx_en(tx_en)
);

// File: tb/sim_txfault_monitor.sv
`timescale 1ns/1ps
module sim_txfault_monitor;
  localparam int TL = 8;
  localparam int BL = 12;
  localparam int FC = 4;

  logic clk = 1'b0;
  logic rst = 1'b1, tick = 1'b1, txd = 1'b1, bus_dom = 1'b0;
  logic bus_short = 1'b0, txrx_short = 1'b0, overtemp = 1'b0;
  logic [1:0] mode = 2'd0;
  logic bus_fail, local_fail, tx_en;

  always #2.5 clk = ~clk;

  txfault_monitor #(.TXD_TO_TICKS(TL), .BUS_TO_TICKS(BL), .FAIL_CYCLES(FC)) u0 (
    .clk(clk), .rst(rst), .tick(tick), .txd(txd), .bus_dom(bus_dom),
    .bus_short(bus_short), .txrx_short(txrx_short), .overtemp(overtemp),
    .mode(mode), .bus_fail(bus_fail), .local_fail(local_fail), .tx_en(tx_en)
  );

  int vectors = 0, miscompares = 0, cycles = 0;
  bit started = 0, done = 0;
  string phase = "R1";

  // Behavioural reference model, updated at each rising edge.
  int  m_tcnt, m_bcnt, m_run, m_modeq;
  bit  m_txen, m_lf, m_bf, m_txdq;

  always @(posedge clk) begin
    bit mon, entry, texp, bexp, setf, rel, armed;
    started = 1;
    cycles++;
    if (rst) begin
      m_tcnt = 0; m_bcnt = 0; m_run = 0; m_modeq = 0;
      m_txen = 1; m_lf = 0; m_bf = 0; m_txdq = 1;
    end else begin
      mon   = (mode == 2'd1) || (mode == 2'd2);
      entry = (mode == 2'd1) && (m_modeq != 1);
      texp  = mon && !txd && (m_tcnt == TL);
      bexp  = mon && bus_dom && (m_bcnt == BL);
      setf  = mon && (texp || overtemp || txrx_short);
      rel   = txd && !overtemp && !txrx_short && (entry || bus_dom);
      armed = (mode == 2'd1) && m_txen;
      if (entry) begin
        m_run = 0; m_bf = 0;
      end else if (!armed) begin
        m_run = 0;
      end else if (!m_txdq && txd) begin
        if (!bus_short) m_run = 0;
        else if (m_run == FC - 1) m_bf = 1;
        else m_run++;
      end
      if (setf) m_txen = 0;
      else if (rel) m_txen = 1;
      m_lf = !m_txen || bexp;
      if (!(mon && !txd)) m_tcnt = 0;
      else if (tick && m_tcnt < TL) m_tcnt++;
      if (!(mon && bus_dom)) m_bcnt = 0;
      else if (tick && m_bcnt < BL) m_bcnt++;
      m_txdq = txd;
      m_modeq = int'(mode);
    end
  end

  task automatic cmp(string what, logic act, bit exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual=%b expected=%b at t=%0t", phase, what, act, exp, $time);
    end
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (started) begin
        cmp("bus_fail", bus_fail, m_bf);
        cmp("local_fail", local_fail, m_lf);
        cmp("tx_en", tx_en, m_txen);
      end
    end
  endtask

  task automatic chk(string tag, string what, logic act, bit exp);
    string save;
    save = phase; phase = tag;
    cmp(what, act, exp);
    phase = save;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  // one TXD cycle: two dominant cycles, then a recessive edge with given short level
  task automatic txd_cycle(bit shorted);
    txd = 1'b0; cyc(2);
    txd = 1'b1; bus_short = shorted; cyc(1);
    bus_short = 1'b0; cyc(1);
  endtask

  always @(posedge clk) if (cycles > 20000) begin
    miscompares++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finish_run();
  end

  initial begin
    cyc(3);
    chk("R1", "tx_en", tx_en, 1); chk("R1", "local_fail", local_fail, 0);
    chk("R1", "bus_fail", bus_fail, 0);
    rst = 1'b0; cyc(1);
    chk("R1", "tx_en", tx_en, 1); chk("R1", "local_fail", local_fail, 0);

    phase = "R2"; mode = 2'd1; cyc(2);
    txd = 1'b0; cyc(TL + 4);
    chk("R2", "tx_en", tx_en, 0); chk("R2", "local_fail", local_fail, 1);
    phase = "R5"; txd = 1'b1; cyc(4);
    chk("R5", "tx_en", tx_en, 0); chk("R5", "local_fail", local_fail, 1);
    phase = "R6"; bus_dom = 1'b1; cyc(2);
    chk("R6", "tx_en", tx_en, 1); chk("R6", "local_fail", local_fail, 0);

    phase = "R3"; cyc(BL + 4);
    chk("R3", "local_fail", local_fail, 1); chk("R3", "tx_en", tx_en, 1);
    phase = "R4"; bus_dom = 1'b0; cyc(2);
    chk("R4", "local_fail", local_fail, 0);

    phase = "R7"; mode = 2'd2; overtemp = 1'b1; cyc(2);
    chk("R7", "tx_en", tx_en, 0); chk("R7", "local_fail", local_fail, 1);
    phase = "R6"; bus_dom = 1'b1; cyc(2);
    chk("R6", "tx_en", tx_en, 0);
    overtemp = 1'b0; bus_dom = 1'b0; cyc(3);
    chk("R5", "tx_en", tx_en, 0);
    mode = 2'd0; cyc(2); mode = 2'd1; cyc(2);
    chk("R6", "tx_en", tx_en, 1); chk("R6", "local_fail", local_fail, 0);

    phase = "R7"; txrx_short = 1'b1; cyc(1); txrx_short = 1'b0; cyc(2);
    chk("R7", "tx_en", tx_en, 0);
    bus_dom = 1'b1; cyc(1); bus_dom = 1'b0; cyc(2);
    chk("R6", "tx_en", tx_en, 1);

    phase = "R8"; mode = 2'd0; overtemp = 1'b1; txrx_short = 1'b1; txd = 1'b0;
    bus_dom = 1'b1; cyc(BL + 6);
    chk("R8", "tx_en", tx_en, 1); chk("R8", "local_fail", local_fail, 0);
    mode = 2'd3; cyc(4);
    chk("R8", "tx_en", tx_en, 1); chk("R8", "local_fail", local_fail, 0);
    overtemp = 1'b0; txrx_short = 1'b0; txd = 1'b1; bus_dom = 1'b0;

    phase = "R9"; mode = 2'd1; cyc(2);
    for (int k = 0; k < FC - 1; k++) txd_cycle(1);
    txd_cycle(0);
    for (int k = 0; k < FC - 1; k++) txd_cycle(1);
    chk("R9", "bus_fail", bus_fail, 0);
    txd_cycle(1);
    chk("R9", "bus_fail", bus_fail, 1);
    phase = "R10"; mode = 2'd2; cyc(3); mode = 2'd0; cyc(3);
    chk("R10", "bus_fail", bus_fail, 1);
    mode = 2'd1; cyc(2);
    chk("R10", "bus_fail", bus_fail, 0);

    phase = "R11"; tick = 1'b0; txd = 1'b0; cyc(3 * TL);
    chk("R11", "tx_en", tx_en, 1);
    for (int k = 0; k < 3 * TL; k++) begin
      tick = (k % 3 == 0); cyc(1);
    end
    tick = 1'b1; txd = 1'b1; cyc(2);
    chk("R11", "tx_en", tx_en, 0);
    bus_dom = 1'b1; cyc(1); bus_dom = 1'b0; cyc(3);

    finish_run();
  end
endmodule